// File: doc/BRIEF.md
# Programmable-Phase Quadrature Clock Divider

This block divides one fast tick clock down to a pair of equal-frequency square waves, a reference output and a companion output whose phase relative to the reference is selectable among four settings: in phase, a quarter period late, half a period (inverted), and three quarters of a period late. Each input tick is treated as one quarter of a synthesizer oscillator period. An even integer divisor D sets the output period to 4·D ticks with a 50% duty cycle. The companion output is shifted by whole ticks, so a shift of D ticks is an exact quarter period at every divisor, and no divide-by-four flip-flop stage is needed to produce quadrature.

Software or a parent block presents a divisor and a phase selection and pulses a load strobe. An illegal divisor (odd, or below 4) is dropped and the old settings stay in force. A legal request is held pending and takes effect on the next rising edge of the reference output, so both outputs change settings only at a period boundary. Moving between the quarter-period and three-quarter-period settings swaps which output leads, which a downstream quadrature detector sees as a sideband swap.

Top module: `quadclk_phase_div`

## Requirements
- R1: While reset is asserted both outputs are low; on the first clock edge after release the reference output `clk0Out` goes high.
- R2: The reference output has a period of 4·D edges, high for 2·D and low for 2·D, with its rising edge at the start of each period.
- R3: Phase selection code 0 makes `clk1Out` equal to `clk0Out` on every cycle.
- R4: Phase selection code 1 makes `clk1Out` rise exactly D edges after each `clk0Out` rising edge; after reset `clk1Out` stays low until D edges have passed since the first reference edge.
- R5: Phase selection code 2 makes `clk1Out` the inverse of `clk0Out`.
- R6: Phase selection code 3 makes `clk1Out` lag by 3·D edges, so `clk0Out` rises exactly D edges after each `clk1Out` rising edge.
- R7: A load with an even divisor from 4 to 126 is accepted; a load with an odd divisor or a divisor below 4 is ignored and the output period and phase are unchanged.
- R8: An accepted load takes effect at the next `clk0Out` rising edge (period wrap), never mid-period; if several legal loads arrive before that edge, the last one is applied.
- R9: The largest divisor, 126, gives a 504-edge period with a 126-edge lag in code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one tick per quarter oscillator period |
| rstN | input | 1 | Asynchronous active-low reset |
| divIn | input | 7 | Requested divisor D |
| modeIn | input | 2 | Requested phase code: 0 = 0°, 1 = 90°, 2 = 180°, 3 = 270° |
| loadIn | input | 1 | Load strobe, samples divIn and modeIn |
| clk0Out | output | 1 | Reference divided clock |
| clk1Out | output | 1 | Phase-shifted divided clock |

## Verification
The hardest situation to reach is a settings change that lands in the middle of a period, especially a second legal load overriding the first before the boundary, and an illegal load between them. The stimulus issues such loads at arbitrary offsets into the period and follows them at once with further loads, while a behavioural model tracks pending and active settings and checks both outputs on every cycle, so any runt pulse or early switch shows as a mismatch. The largest divisor is run for two full 504-edge periods to reach the wrap of the widest phase count.

// File: rtl/quadclk_pkg.sv
package quadclk_pkg;

  typedef enum logic [1:0] {
    PH_0   = 2'd0,
    PH_90  = 2'd1,
    PH_180 = 2'd2,
    PH_270 = 2'd3
  } phaseSel_t;

  // Strobes from control to datapath, valid for the coming clock edge
  typedef struct packed {
    logic applyCfg;   // pending settings switch in at this edge
    logic lagOn;      // companion output delayed by D ticks
    logic invOn;      // companion output inverted (half-period shift)
  } ctrlStrobe_t;

endpackage

// File: rtl/quadclk_ctrl.sv
module quadclk_ctrl
  import quadclk_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int RESET_DIV  = 4,
  parameter int RESET_MODE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  logic [1:0]       modeIn,
  input  logic             loadIn,
  input  logic             atWrap,
  output ctrlStrobe_t      strobe,
  output logic [DIV_W-1:0] nxtDiv,
  output logic [DIV_W-1:0] curDiv
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(4);
  localparam logic [DIV_W-1:0] MAX_DIV = DIV_W'((1 << DIV_W) - 2);
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(RESET_DIV);
  localparam phaseSel_t        RST_SEL = phaseSel_t'(RESET_MODE);

  logic             pendValid;
  logic [DIV_W-1:0] pendDiv;
  phaseSel_t        pendMode;
  logic [DIV_W-1:0] actDiv;
  phaseSel_t        actMode;
  phaseSel_t        nxtMode;
  logic             loadOk;
  logic             applyNow;

  assign loadOk   = loadIn && !divIn[0] && (divIn >= MIN_DIV) && (divIn <= MAX_DIV);
  assign applyNow = pendValid && atWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendDiv   <= RST_DIV;
      pendMode  <= RST_SEL;
      actDiv    <= RST_DIV;
      actMode   <= RST_SEL;
    end else begin
      if (applyNow) begin
        actDiv  <= pendDiv;
        actMode <= pendMode;
      end
      if (loadOk) begin
        pendValid <= 1'b1;
        pendDiv   <= divIn;
        pendMode  <= phaseSel_t'(modeIn);
      end else if (applyNow) begin
        pendValid <= 1'b0;
      end
    end
  end

  always_comb begin
    nxtMode         = applyNow ? pendMode : actMode;
    nxtDiv          = applyNow ? pendDiv  : actDiv;
    strobe.applyCfg = applyNow;
    strobe.lagOn    = (nxtMode == PH_90) || (nxtMode == PH_270);
    strobe.invOn    = (nxtMode == PH_180) || (nxtMode == PH_270);
  end

  assign curDiv = actDiv;

  // R7: a rejected load leaves the pending request untouched
  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (loadIn && !loadOk) |=> ($stable(pendDiv) && $stable(pendMode)));

  // R7: the active divisor is always a legal even value
  assert_div_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!actDiv[0] && actDiv >= MIN_DIV && actDiv <= MAX_DIV));

  // R8: active settings only move at a period wrap reported by the datapath
  assert_switch_at_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actDiv) |-> $past(atWrap));

endmodule

// File: rtl/quadclk_datapath.sv
module quadclk_datapath
  import quadclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [DIV_W-1:0] nxtDiv,
  input  logic [DIV_W-1:0] curDiv,
  output logic             atWrap,
  output logic             clk0Out,
  output logic             clk1Out
);

  localparam int PH_W  = DIV_W + 2;   // holds 4*D - 1
  localparam int CNT_W = DIV_W + 1;   // startup counter, saturates above any lag
  localparam logic [CNT_W-1:0] ELAP_MAX = '1;

  logic             running;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] elapsed;
  logic             armed;
  logic             clk0Q;
  logic             clk1Q;

  logic [PH_W-1:0]  curPeriod;
  logic [PH_W-1:0]  nxtPeriod;
  logic [PH_W-1:0]  nxtHalf;
  logic [PH_W-1:0]  phaseNext;
  logic [CNT_W-1:0] elapsedNext;
  logic [PH_W-1:0]  lagNext;
  logic [PH_W-1:0]  shifted;
  logic             armedNext;
  logic             clk0Next;
  logic             clk1Next;

  always_comb begin
    curPeriod   = {curDiv, 2'b00};
    nxtPeriod   = {nxtDiv, 2'b00};
    nxtHalf     = {1'b0, nxtDiv, 1'b0};
    atWrap      = running && (phase == curPeriod - PH_W'(1));
    phaseNext   = (!running || atWrap) ? '0 : phase + PH_W'(1);
    elapsedNext = !running ? '0 :
                  ((elapsed == ELAP_MAX) ? elapsed : elapsed + CNT_W'(1));
    lagNext     = strobe.lagOn ? {2'b00, nxtDiv} : '0;
    armedNext   = armed || ({1'b0, elapsedNext} >= lagNext);
    shifted     = (phaseNext >= lagNext) ? (phaseNext - lagNext)
                                         : (phaseNext + nxtPeriod - lagNext);
    clk0Next    = phaseNext < nxtHalf;
    clk1Next    = armedNext && ((shifted < nxtHalf) ^ strobe.invOn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= '0;
      elapsed <= '0;
      armed   <= 1'b0;
      clk0Q   <= 1'b0;
      clk1Q   <= 1'b0;
    end else begin
      running <= 1'b1;
      phase   <= phaseNext;
      elapsed <= elapsedNext;
      armed   <= armedNext;
      clk0Q   <= clk0Next;
      clk1Q   <= clk1Next;
    end
  end

  assign clk0Out = clk0Q;
  assign clk1Out = clk1Q;

  // R1: the reference output is high right after the first edge
  assert_first_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> clk0Out);

  // R2: the phase count never reaches the active period
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (phase < curPeriod));

  // R2: the reference output falls exactly half a period in
  assert_high_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clk0Out) |-> (phase == {1'b0, curDiv, 1'b0}));

  // R8: the reference output rises only at the start of a period
  assert_rise_at_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clk0Out) |-> (phase == '0));

  // R4: once the companion output is released it stays released
  assert_armed_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

endmodule

// File: rtl/quadclk_phase_div.sv
module quadclk_phase_div
  import quadclk_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int RESET_DIV  = 4,
  parameter int RESET_MODE = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  logic [1:0]       modeIn,
  input  logic             loadIn,
  output logic             clk0Out,
  output logic             clk1Out
);

  ctrlStrobe_t      strobe;
  logic [DIV_W-1:0] nxtDiv;
  logic [DIV_W-1:0] curDiv;
  logic             atWrap;

  quadclk_ctrl #(
    .DIV_W      (DIV_W),
    .RESET_DIV  (RESET_DIV),
    .RESET_MODE (RESET_MODE)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .divIn  (divIn),
    .modeIn (modeIn),
    .loadIn (loadIn),
    .atWrap (atWrap),
    .strobe (strobe),
    .nxtDiv (nxtDiv),
    .curDiv (curDiv)
  );

  quadclk_datapath #(
    .DIV_W (DIV_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .nxtDiv  (nxtDiv),
    .curDiv  (curDiv),
    .atWrap  (atWrap),
    .clk0Out (clk0Out),
    .clk1Out (clk1Out)
  );

endmodule

// File: tb/quadclk_phase_div_tb.sv
module quadclk_phase_div_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] divIn = 7'd0;
  logic [1:0] modeIn = 2'd0;
  logic       loadIn = 1'b0;
  logic       clk0Out;
  logic       clk1Out;

  int checks = 0;
  int failures = 0;
  string curTag = "R1";

  // behavioural reference state
  int  mRun = 0, mPhase = 0, mElap = 0, mArm = 0;
  int  mDiv = 4, mMode = 1, mPend = 0, pDiv = 4, pMode = 1;
  bit  e0 = 0, e1 = 0;

  always #5 clk = ~clk;

  quadclk_phase_div u_dut (
    .clk     (clk),
    .rstN    (rstN),
    .divIn   (divIn),
    .modeIn  (modeIn),
    .loadIn  (loadIn),
    .clk0Out (clk0Out),
    .clk1Out (clk1Out)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      mRun = 0; mPhase = 0; mElap = 0; mArm = 0;
      mDiv = 4; mMode = 1; mPend = 0; pDiv = 4; pMode = 1;
      e0 = 0; e1 = 0;
    end else begin
      int  lag, sh, per;
      bit  wrap, app, okL;
      wrap = (mRun != 0) && (mPhase == 4 * mDiv - 1);
      app  = (mPend != 0) && wrap;
      okL  = loadIn && (divIn % 2 == 0) && (divIn >= 4) && (divIn <= 126);
      if (app) begin mDiv = pDiv; mMode = pMode; end
      if (okL) begin pDiv = divIn; pMode = modeIn; mPend = 1; end
      else if (app) mPend = 0;
      mPhase = (mRun == 0 || wrap) ? 0 : mPhase + 1;
      mElap  = (mRun == 0) ? 0 : ((mElap < 255) ? mElap + 1 : 255);
      mRun   = 1;
      lag = (mMode % 2 == 1) ? mDiv : 0;
      if (mElap >= lag) mArm = 1;
      per = 4 * mDiv;
      sh  = (mPhase - lag + per) % per;
      e0  = (mPhase < 2 * mDiv);
      e1  = (mArm != 0) && ((sh < 2 * mDiv) != (mMode >= 2));
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && mRun != 0) begin
      chk(clk0Out == e0, {curTag, " clk0"}, clk0Out, e0);
      chk(clk1Out == e1, {curTag, " clk1"}, clk1Out, e1);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit sig(int s);
    return (s == 1) ? clk1Out : clk0Out;
  endfunction

  task automatic waitRise(int s);
    bit prev;
    int g = 0;
    do begin
      prev = sig(s);
      tick(1);
      g++;
    end while (!(sig(s) && !prev) && g < 2000);
  endtask

  task automatic highLen(output int len);
    len = 0;
    waitRise(0);
    while (clk0Out && len < 2000) begin tick(1); len++; end
  endtask

  // edges from a rise on output a until output b is high
  task automatic riseGap(int a, int b, output int gap);
    gap = 0;
    waitRise(a);
    while (!sig(b) && gap < 2000) begin tick(1); gap++; end
  endtask

  task automatic doLoad(int d, int m);
    divIn = 7'(d); modeIn = 2'(m); loadIn = 1'b1;
    tick(1);
    loadIn = 1'b0;
  endtask

  initial begin
    int v;
    int bad;
    tick(3);
    chk(clk0Out == 0, "R1 clk0 in reset", clk0Out, 0);
    chk(clk1Out == 0, "R1 clk1 in reset", clk1Out, 0);
    rstN = 1'b1;
    tick(1);
    chk(clk0Out == 1, "R1 clk0 after first edge", clk0Out, 1);
    chk(clk1Out == 0, "R4 clk1 held at start", clk1Out, 0);
    tick(3);
    chk(clk1Out == 0, "R4 clk1 held until lag", clk1Out, 0);
    tick(1);
    chk(clk1Out == 1, "R4 clk1 released after D", clk1Out, 1);
    curTag = "R4";
    tick(40);

    curTag = "R3";
    doLoad(8, 0);
    tick(80);
    highLen(v); chk(v == 16, "R2 high length D=8", v, 16);
    riseGap(0, 1, v); chk(v == 0, "R3 in phase", v, 0);

    curTag = "R5";
    doLoad(10, 2);
    tick(90);
    bad = 0;
    for (int i = 0; i < 50; i++) begin
      if (clk1Out == clk0Out) bad++;
      tick(1);
    end
    chk(bad == 0, "R5 inverse mismatches", bad, 0);

    curTag = "R6";
    doLoad(6, 3);
    tick(90);
    riseGap(1, 0, v); chk(v == 6, "R6 clk0 after clk1", v, 6);

    curTag = "R4";
    doLoad(6, 1);
    tick(60);
    riseGap(0, 1, v); chk(v == 6, "R4 lag D=6", v, 6);

    curTag = "R7";
    doLoad(127, 2);
    tick(5);
    doLoad(2, 0);
    tick(60);
    highLen(v); chk(v == 12, "R7 period kept after bad loads", v, 12);
    riseGap(0, 1, v); chk(v == 6, "R7 phase kept after bad loads", v, 6);
    doLoad(4, 0);
    tick(40);
    highLen(v); chk(v == 8, "R7 smallest divisor accepted", v, 8);

    curTag = "R8";
    tick(3);
    doLoad(12, 1);
    tick(2);
    doLoad(9, 2);
    doLoad(14, 1);
    chk(clk0Out == e0, "R8 no switch before wrap", clk0Out, e0);
    tick(200);
    highLen(v); chk(v == 28, "R8 last legal load wins", v, 28);
    riseGap(0, 1, v); chk(v == 14, "R8 lag of last load", v, 14);

    curTag = "R9";
    doLoad(126, 1);
    tick(1100);
    highLen(v); chk(v == 252, "R9 high length D=126", v, 252);
    riseGap(0, 1, v); chk(v == 126, "R9 lag D=126", v, 126);

    curTag = "R1";
    rstN = 1'b0;
    tick(2);
    chk(clk0Out == 0 && clk1Out == 0, "R1 outputs low on reset", clk0Out + clk1Out, 0);
    rstN = 1'b1;
    tick(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule